// File: doc/BRIEF.md
# Reloadable Timer with Sticky Overflow Flag

This block is a 16-bit up-counting timer that moves one step on each cycle where a slow tick enable is high. It is controlled through a small register port. Software writes a start value into a reload register and then sets a run bit. Setting the run bit loads the counter from the reload register and starts it in the same operation. To get a period of N ticks, software writes 0x10000 minus N as the reload value.

When the counter steps past its all-ones value, three things happen. It reloads from the reload register, it keeps running, and it sets a sticky request flag. The flag can be read in a status register and is also driven on a request output. Software clears the flag by writing a one to the matching bit of a write-one-to-clear register. This clear works only while the timer is stopped. A clear that arrives while the timer runs is dropped, so software must first stop the timer and then clear the flag.

The register port takes one write per cycle. Reads are combinational on the read address. The current count is also readable, so the wrap-around behaviour can be observed.

Top module: `tmr_sticky_top`

## Requirements
- R1: After reset, and while reset is held, every readable register reads zero and `req_o` is low. The readable registers are reload, control, status, clear and count.
- R2: A write to address 0 stores all 16 bits of the reload value. A read of address 0 returns the stored value.
- R3: A write to address 1 with bit 0 set does two things in the same clock edge: it loads the counter from the reload register and it sets the run bit. This also holds when the timer is already running. A read of address 1 returns the run bit at bit 0 and zeros elsewhere.
- R4: A write to address 1 with bit 0 clear stops the timer. While stopped, the count holds its value regardless of the tick enable.
- R5: While running, the count rises by exactly one on each edge where `tick_en` is high, and it holds on edges where `tick_en` is low. A control write in the same cycle as a tick takes precedence over that tick.
- R6: A tick while the count is 0xFFFF does three things: it reloads the count from the reload register, it sets the flag, and it leaves the timer running. The period is therefore 0x10000 minus the reload value, measured in ticks.
- R7: A read of address 2 returns the flag at bit 10 and zeros in all other bits. `req_o` equals the flag.
- R8: While the timer is stopped, a write to address 3 with bit 10 set clears the flag. A write to address 3 with bit 10 clear leaves the flag unchanged, whatever the other bits hold. A stopped timer never sets the flag.
- R9: While the timer is running, a write to address 3 leaves the flag set. An overflow always sets the flag.
- R10: A read of address 4 returns the current count.
- R11: Writes to address 2 (status) or address 4 (count) change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-step enable from the slow time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| req_o | output | 1 | Sticky overflow request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 16-bit data path and the flag at bit 10. With these values the reload can be set to 0x10000 minus 100, which gives a long period that reaches 0xFFFF and overflows in exactly 100 ticks. The reload can also be set to 0xFFFD, which gives a short period that shows two wraps in a row. Because the counter width matches the data width, the count read-back shows every bit of the counter, including the wrap boundary itself.

// File: rtl/tmr_pkg.sv
// Package: register addresses shared by the timer modules, checker and bench.
// Assumes a 3-bit register address space.
package tmr_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLR    = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;
endpackage

// File: rtl/tmr_regif.sv
// Register interface: decodes writes into a reload value and command strobes,
// and multiplexes the readable state onto rd_data.
// Assumes one write per cycle and DATA_W >= CNT_W, DATA_W > FLAG_BIT.
module tmr_regif #(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16,
    parameter int FLAG_BIT = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [tmr_pkg::ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [tmr_pkg::ADDR_W-1:0] rd_addr,
    input  logic                       run,
    input  logic                       flag,
    input  logic [CNT_W-1:0]           cnt,
    output logic [CNT_W-1:0]           reload,
    output logic                       start_cmd,
    output logic                       stop_cmd,
    output logic                       clr_cmd,
    output logic [DATA_W-1:0]          rd_data
);
    import tmr_pkg::*;

    logic [CNT_W-1:0] reload_q;

    // Holds the reload value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '0;
        else if (wr_en && wr_addr == A_RELOAD)
            reload_q <= wr_data[CNT_W-1:0];
    end

    assign reload = reload_q;

    // Turns control and clear writes into single-cycle commands.
    always_comb begin
        start_cmd = wr_en && wr_addr == A_CTRL && wr_data[0];
        stop_cmd  = wr_en && wr_addr == A_CTRL && !wr_data[0];
        clr_cmd   = wr_en && wr_addr == A_CLR && wr_data[FLAG_BIT];
    end

    // Selects the register addressed by rd_addr; unmapped and write-only read zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_RELOAD: rd_data[CNT_W-1:0] = reload_q;
            A_CTRL:   rd_data[0]         = run;
            A_STAT:   rd_data[FLAG_BIT]  = flag;
            A_COUNT:  rd_data[CNT_W-1:0] = cnt;
            default:  rd_data            = '0;
        endcase
    end
endmodule

// File: rtl/tmr_counter.sv
// Counter core: holds the run state and the count, advances on tick_en,
// wraps to the reload value and emits a one-cycle overflow pulse.
// Assumes start_cmd and stop_cmd are never high together.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic [CNT_W-1:0] reload,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             step;

    // A step happens only when running, ticked and not overridden by a control write.
    always_comb begin
        step = run_q && tick_en && !start_cmd && !stop_cmd;
        ovf  = step && cnt_q == CNT_MAX;
    end

    // Updates run state and count; control writes win over ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_cmd) begin
            run_q <= 1'b1;
            cnt_q <= reload;
        end else if (stop_cmd) begin
            run_q <= 1'b0;
        end else if (ovf) begin
            cnt_q <= reload;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign run = run_q;
    assign cnt = cnt_q;
endmodule

// File: rtl/tmr_flag.sv
// Sticky request flag: set by overflow, cleared by a clear command only while stopped.
// Assumes ovf can only pulse while the timer runs.
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic clr_cmd,
    input  logic run,
    output logic flag
);
    logic flag_q;

    // Set has priority; a clear is accepted only when the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (ovf)
            flag_q <= 1'b1;
        else if (clr_cmd && !run)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;
endmodule

// File: rtl/tmr_sticky_top.sv
// Top level: reloadable up-counting timer with a sticky overflow flag whose
// clear is blocked while running. Assumes tick_en is already in the clk domain.
module tmr_sticky_top #(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16,
    parameter int FLAG_BIT = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_en,
    input  logic                       wr_en,
    input  logic [tmr_pkg::ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [tmr_pkg::ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       req_o
);
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] cnt_w;
    logic             run_w;
    logic             flag_w;
    logic             ovf_w;
    logic             start_w;
    logic             stop_w;
    logic             clr_w;

    tmr_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_regif (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .run(run_w), .flag(flag_w),
        .cnt(cnt_w), .reload(reload_w), .start_cmd(start_w),
        .stop_cmd(stop_w), .clr_cmd(clr_w), .rd_data(rd_data)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start_cmd(start_w),
        .stop_cmd(stop_w), .reload(reload_w), .run(run_w), .cnt(cnt_w),
        .ovf(ovf_w)
    );

    tmr_flag u_flag (
        .clk(clk), .rst_n(rst_n), .ovf(ovf_w), .clr_cmd(clr_w),
        .run(run_w), .flag(flag_w)
    );

    assign req_o = flag_w;
endmodule

// File: rtl/tmr_sticky_chk.sv
// Checker: temporal properties of the timer, bound into tmr_sticky_top.
module tmr_sticky_chk #(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16,
    parameter int FLAG_BIT = 10
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tick_en,
    input logic                       wr_en,
    input logic [tmr_pkg::ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0]          wr_data,
    input logic [tmr_pkg::ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0]          rd_data,
    input logic                       run,
    input logic [CNT_W-1:0]           cnt,
    input logic [CNT_W-1:0]           reload,
    input logic                       flag
);
    import tmr_pkg::*;
    localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'(1) << FLAG_BIT;

    logic ctrl_wr;
    assign ctrl_wr = wr_en && wr_addr == A_CTRL;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[0]) |=> (run && cnt == $past(reload))); // R3
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ctrl_wr) |=> $stable(cnt)); // R4
    AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick_en && !ctrl_wr) |=> $stable(cnt)); // R5
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && !ctrl_wr && cnt == CNT_MAX) |=> (flag && run && cnt == $past(reload))); // R6
    AST_STATUS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_STAT) |-> ((rd_data & ~STAT_MASK) == '0)); // R7
    AST_NO_SET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !flag) |=> !flag); // R8
    AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && flag) |=> flag); // R9
endmodule

bind tmr_sticky_top tmr_sticky_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .run(run_w), .cnt(cnt_w), .reload(reload_w),
    .flag(flag_w)
);

// File: tb/tmr_sticky_top_tb.sv
// Directed bench for tmr_sticky_top: one task per scenario.
module tmr_sticky_top_tb;
    import tmr_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        req_o;

    int n_checks = 0;
    int n_fail = 0;

    tmr_sticky_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .req_o(req_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reset read", v, 16'h0000);
        end
        chk("R1 reset req_o", 16'(req_o), 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_reload_rw();
        logic [15:0] v;
        wr(A_RELOAD, 16'hA5C3);
        rd(A_RELOAD, v); chk("R2 reload readback", v, 16'hA5C3);
        wr(A_STAT, 16'hFFFF);
        rd(A_STAT, v); chk("R11 status write ignored", v, 16'h0000);
        wr(A_COUNT, 16'h1234);
        rd(A_COUNT, v); chk("R11 count write ignored", v, 16'h0000);
    endtask

    task automatic t_long_period();
        logic [15:0] v;
        wr(A_RELOAD, 16'hFF9C);
        wr(A_CTRL, 16'h0001);
        rd(A_COUNT, v); chk("R3 start loads", v, 16'hFF9C);
        rd(A_CTRL, v);  chk("R3 run bit", v, 16'h0001);
        ticks(99);
        rd(A_COUNT, v); chk("R10 count at max", v, 16'hFFFF);
        rd(A_STAT, v);  chk("R6 no flag before period", v, 16'h0000);
        ticks(1);
        rd(A_STAT, v);  chk("R7 flag at bit 10", v, 16'h0400);
        chk("R7 req_o", 16'(req_o), 16'h0001);
        rd(A_COUNT, v); chk("R6 wrap to reload", v, 16'hFF9C);
        rd(A_CTRL, v);  chk("R6 still running", v, 16'h0001);
    endtask

    task automatic t_clear_running();
        logic [15:0] v;
        wr(A_CLR, 16'h0400);
        rd(A_STAT, v); chk("R9 clear ignored while running", v, 16'h0400);
        chk("R9 req_o held", 16'(req_o), 16'h0001);
    endtask

    task automatic t_stop_and_clear();
        logic [15:0] v, held;
        wr(A_CTRL, 16'h0000);
        rd(A_CTRL, v); chk("R4 stopped", v, 16'h0000);
        rd(A_COUNT, held);
        ticks(7);
        rd(A_COUNT, v); chk("R4 count holds", v, held);
        wr(A_CLR, 16'hFBFF);
        rd(A_STAT, v); chk("R8 bit10 clear no effect", v, 16'h0400);
        wr(A_CLR, 16'h0400);
        rd(A_STAT, v); chk("R8 clear while stopped", v, 16'h0000);
        chk("R8 req_o low", 16'(req_o), 16'h0000);
        wr(A_RELOAD, 16'hFFFF);
        ticks(20);
        rd(A_STAT, v); chk("R8 stopped never sets flag", v, 16'h0000);
    endtask

    task automatic t_tick_gating();
        logic [15:0] v;
        wr(A_RELOAD, 16'hFFF0);
        wr(A_CTRL, 16'h0001);
        repeat (10) @(negedge clk);
        rd(A_COUNT, v); chk("R5 no tick no step", v, 16'hFFF0);
        for (int i = 0; i < 4; i++) begin
            ticks(1);
            @(negedge clk);
        end
        rd(A_COUNT, v); chk("R5 sparse ticks", v, 16'hFFF4);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; wr_addr = A_CTRL; wr_data = 16'h0001;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
        rd(A_COUNT, v); chk("R5 control wins over tick", v, 16'hFFF0);
    endtask

    task automatic t_periodic();
        logic [15:0] v;
        wr(A_CTRL, 16'h0000);
        wr(A_CLR, 16'h0400);
        wr(A_RELOAD, 16'hFFFD);
        wr(A_CTRL, 16'h0001);
        ticks(3);
        rd(A_STAT, v);  chk("R6 short period flag", v, 16'h0400);
        rd(A_COUNT, v); chk("R6 first wrap", v, 16'hFFFD);
        ticks(2);
        rd(A_COUNT, v); chk("R6 climbing again", v, 16'hFFFF);
        wr(A_CTRL, 16'h0001);
        rd(A_COUNT, v); chk("R3 restart reloads while running", v, 16'hFFFD);
        ticks(3);
        rd(A_COUNT, v); chk("R6 second wrap", v, 16'hFFFD);
    endtask

    task automatic t_reset_midrun();
        logic [15:0] v;
        ticks(1);
        rst_n = 1'b0;
        @(negedge clk);
        rd(A_CTRL, v);   chk("R1 run cleared", v, 16'h0000);
        rd(A_COUNT, v);  chk("R1 count cleared", v, 16'h0000);
        rd(A_RELOAD, v); chk("R1 reload cleared", v, 16'h0000);
        rd(A_STAT, v);   chk("R1 flag cleared", v, 16'h0000);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_reload_rw();
        t_long_period();
        t_clear_running();
        t_stop_and_clear();
        t_tick_gating();
        t_periodic();
        t_reset_midrun();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule